// File: doc/BRIEF.md
# Elliptic-Curve Scalar Multiplication Sequencer

This block steers a binary-field elliptic-curve point multiplier. It does no arithmetic itself. It emits a stream of field-level micro-commands to an external arithmetic unit, one at a time. Each command is flagged by a single-cycle request strobe. The controller then waits for that unit to signal completion before it moves on. No step depends on a fixed cycle count, so the arithmetic unit may take any time for any command.

Control has two levels. An outer, level-based loop handles the point multiplication:
- It first issues the setup commands.
- It then scans the loaded scalar from the most significant end, shifting it left by one position per iteration.
- For every bit it requests a point doubling.
- When the bit is one, it follows the doubling with a point addition.

A pulse-based inner sequencer expands each point operation into a list of micro-steps:
- A doubling contains seven field multiplications.
- An addition contains thirteen.
- Each multiplication takes four micro-steps: load operand A, load operand B, multiply, move the result.

The loop ends after the requested number of bits, or at the first iteration boundary where stop is high. It then raises a done flag.

Top module: `ecsm_seq_ctrl`

## Requirements
- R1: After reset, the outputs are idle: cmd_req_o=0, busy_o=0 and done_o=0.
- R2: A start pulse while idle issues three setup commands, in this order, before any doubling: load X (op 4), clear Z (op 5), load Y (op 6). The index field is 0 for all three.
- R3: Scalar bits are consumed from bit KMAX-1 downward, one per iteration, by a left shift. An addition is issued in an iteration exactly when the bit consumed in that iteration is 1.
- R4: In each iteration, a doubling comes first: MULS_DBL multiplications. When the bit is 1, an addition follows: MULS_ADD multiplications. Each multiplication m is issued as four commands in the order op 0 (load A), op 1 (load B), op 2 (multiply), op 3 (move), all with index m. The index m counts from 0 within each point operation.
- R5: cmd_req_o is high for exactly one cycle per command. cmd_op_o and cmd_idx_o hold their values from the request until the completion is accepted.
- R6: No new request is issued until cmd_ack_i has been seen high in a cycle after the request cycle. cmd_ack_i is ignored while no request is outstanding, which includes the request cycle itself and the idle state.
- R7: Exactly len_i bits are processed. A len_i of 0 or above KMAX selects KMAX. After the last one, busy_o falls and done_o rises; done_o stays high until the next start.
- R8: When stop_i is high at the end of an iteration, the loop ends after that iteration and done_o rises.
- R9: While busy_o is high, start_i and scalar_load_i have no effect on the command stream.
- R10: For a run of n bits containing w ones, exactly 7·n + 13·w multiply commands (op 2) are issued, using the default MULS_DBL and MULS_ADD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, honoured only while idle |
| stop_i | input | 1 | Ends the loop at the next iteration boundary |
| len_i | input | LW | Number of scalar bits to process, captured at start |
| scalar_load_i | input | 1 | Loads scalar_i into the scan register while idle |
| scalar_i | input | KMAX | Scalar value; the top bit is consumed first |
| cmd_req_o | output | 1 | One-cycle request strobe for the current command |
| cmd_op_o | output | 3 | Command code: 0 load A, 1 load B, 2 multiply, 3 move, 4 load X, 5 clear Z, 6 load Y |
| cmd_idx_o | output | IDXW | Multiplication index inside the current point operation |
| cmd_ack_i | input | 1 | Completion from the arithmetic unit |
| busy_o | output | 1 | A point multiplication is in progress |
| done_o | output | 1 | Last point multiplication finished |

## Verification
The assertions take two things for granted about the inputs:
- The arithmetic unit never returns a completion in the same cycle as the request.
- start_i, scalar_load_i and stop_i are synchronous levels held for whole cycles.

The stimulus keeps within these assumptions. The responder acknowledges one to three cycles after each request. It also raises extra completions only where R6 says they must be ignored: while idle, and in the request cycle itself. During a run, the stimulus pulses start and scalar load only as deliberate disturbances that R9 says must be ignored. stop_i is changed only between runs. The lengths used stay within 1..KMAX.

// File: rtl/ecsm_pkg.sv
package ecsm_pkg;

   // micro-command codes seen by the arithmetic unit
   typedef enum logic [2:0] {
      UC_LDA  = 3'd0,
      UC_LDB  = 3'd1,
      UC_MUL  = 3'd2,
      UC_MOV  = 3'd3,
      UC_LDX  = 3'd4,
      UC_CLRZ = 3'd5,
      UC_LDY  = 3'd6
   } ucmd_e;

   // point-level operation kinds expanded by the inner sequencer
   typedef enum logic [1:0] {
      PK_INIT = 2'd0,
      PK_DBL  = 2'd1,
      PK_ADD  = 2'd2
   } pop_e;

   localparam int STEPS_PER_MUL = 4;
   localparam int INIT_STEPS    = 3;

endpackage

// File: rtl/ecsm_scalar_reg.sv
module ecsm_scalar_reg #(
   parameter int KMAX = 261
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load_i,
   input  logic [KMAX-1:0] val_i,
   input  logic            shift_i,
   output logic            msb_o
);

   logic [KMAX-1:0] sr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q <= '0;
      end else if (load_i) begin
         sr_q <= val_i;
      end else if (shift_i) begin
         sr_q <= {sr_q[KMAX-2:0], 1'b0};
      end
   end

   assign msb_o = sr_q[KMAX-1];

   initial begin
      assert (KMAX >= 2) else $error("ecsm_scalar_reg: KMAX must be at least 2");
   end

endmodule

// File: rtl/ecsm_useq.sv
module ecsm_useq
   import ecsm_pkg::*;
#(
   parameter int MULS_DBL = 7,
   parameter int MULS_ADD = 13,
   parameter int IDXW     = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            kick_i,
   input  pop_e            kind_i,
   input  logic            ack_i,
   output logic            req_o,
   output logic [2:0]      op_o,
   output logic [IDXW-1:0] idx_o,
   output logic            fin_o
);

   localparam int MAXM  = (MULS_ADD > MULS_DBL) ? MULS_ADD : MULS_DBL;
   localparam int MAXST = STEPS_PER_MUL * MAXM;
   localparam int SW    = $clog2(MAXST + 1);

   typedef enum logic [1:0] {Q_IDLE, Q_ISSUE, Q_WAIT} qst_e;

   qst_e          st;
   pop_e          kind_q;
   logic [SW-1:0] step;
   logic [SW-1:0] last_step;

   always_comb begin
      case (kind_q)
         PK_INIT: last_step = SW'(INIT_STEPS - 1);
         PK_DBL:  last_step = SW'(STEPS_PER_MUL * MULS_DBL - 1);
         default: last_step = SW'(STEPS_PER_MUL * MULS_ADD - 1);
      endcase
   end

   // command decode from the step counter
   always_comb begin
      if (kind_q == PK_INIT) begin
         op_o  = 3'(UC_LDX) + 3'(step);
         idx_o = '0;
      end else begin
         op_o  = {1'b0, step[1:0]};
         idx_o = IDXW'(step >> 2);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= Q_IDLE;
         kind_q <= PK_INIT;
         step   <= '0;
         fin_o  <= 1'b0;
      end else begin
         fin_o <= 1'b0;
         case (st)
            Q_IDLE: begin
               if (kick_i) begin
                  kind_q <= kind_i;
                  step   <= '0;
                  st     <= Q_ISSUE;
               end
            end
            Q_ISSUE: st <= Q_WAIT;
            Q_WAIT: begin
               if (ack_i) begin
                  if (step == last_step) begin
                     fin_o <= 1'b1;
                     st    <= Q_IDLE;
                  end else begin
                     step <= step + 1'b1;
                     st   <= Q_ISSUE;
                  end
               end
            end
            default: st <= Q_IDLE;
         endcase
      end
   end

   assign req_o = (st == Q_ISSUE);

   initial begin
      assert (MULS_DBL >= 1 && MULS_ADD >= 1) else $error("ecsm_useq: multiplication counts must be positive");
      assert ((1 << IDXW) >= MAXM) else $error("ecsm_useq: IDXW too narrow");
   end

   AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) req_o |=> !req_o); // R5
   AST_HOLD_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n) (st == Q_WAIT && !ack_i) |=> (!req_o && $stable(op_o) && $stable(idx_o))); // R6
   AST_FIN_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n) fin_o |-> $past(ack_i)); // R6
   AST_KICK_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n) kick_i |-> (st == Q_IDLE)); // R4

endmodule

// File: rtl/ecsm_seq_ctrl.sv
module ecsm_seq_ctrl
   import ecsm_pkg::*;
#(
   parameter int KMAX     = 261,
   parameter int MULS_DBL = 7,
   parameter int MULS_ADD = 13,
   parameter int LW       = $clog2(KMAX + 1),
   parameter int IDXW     = $clog2((MULS_ADD > MULS_DBL) ? MULS_ADD : MULS_DBL)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_i,
   input  logic            stop_i,
   input  logic [LW-1:0]   len_i,
   input  logic            scalar_load_i,
   input  logic [KMAX-1:0] scalar_i,
   output logic            cmd_req_o,
   output logic [2:0]      cmd_op_o,
   output logic [IDXW-1:0] cmd_idx_o,
   input  logic            cmd_ack_i,
   output logic            busy_o,
   output logic            done_o
);

   typedef enum logic [1:0] {O_IDLE, O_INIT, O_DBL, O_ADD} ost_e;

   ost_e          ost;
   logic [LW-1:0] bit_cnt;
   logic [LW-1:0] len_q;
   logic [LW-1:0] len_eff;
   logic          kick_q;
   pop_e          kind_q;
   logic          done_q;
   logic          seq_fin;
   logic          cur_bit;
   logic          bit_end;
   logic          last_bit;
   logic          shift_en;

   assign len_eff = (len_i == '0 || len_i > LW'(KMAX)) ? LW'(KMAX) : len_i;

   // iteration boundary: doubling of a zero bit or addition has finished
   assign bit_end  = seq_fin && ((ost == O_DBL && !cur_bit) || ost == O_ADD);
   assign last_bit = (bit_cnt == len_q - 1'b1) || stop_i;
   assign shift_en = bit_end && !last_bit;

   ecsm_scalar_reg #(.KMAX(KMAX)) u_sreg (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (scalar_load_i && ost == O_IDLE),
      .val_i  (scalar_i),
      .shift_i(shift_en),
      .msb_o  (cur_bit)
   );

   ecsm_useq #(.MULS_DBL(MULS_DBL), .MULS_ADD(MULS_ADD), .IDXW(IDXW)) u_useq (
      .clk    (clk),
      .rst_n  (rst_n),
      .kick_i (kick_q),
      .kind_i (kind_q),
      .ack_i  (cmd_ack_i),
      .req_o  (cmd_req_o),
      .op_o   (cmd_op_o),
      .idx_o  (cmd_idx_o),
      .fin_o  (seq_fin)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ost     <= O_IDLE;
         bit_cnt <= '0;
         len_q   <= '0;
         kick_q  <= 1'b0;
         kind_q  <= PK_INIT;
         done_q  <= 1'b0;
      end else begin
         kick_q <= 1'b0;
         case (ost)
            O_IDLE: begin
               if (start_i) begin
                  done_q  <= 1'b0;
                  len_q   <= len_eff;
                  bit_cnt <= '0;
                  kick_q  <= 1'b1;
                  kind_q  <= PK_INIT;
                  ost     <= O_INIT;
               end
            end
            O_INIT: begin
               if (seq_fin) begin
                  kick_q <= 1'b1;
                  kind_q <= PK_DBL;
                  ost    <= O_DBL;
               end
            end
            O_DBL, O_ADD: begin
               if (seq_fin && ost == O_DBL && cur_bit) begin
                  kick_q <= 1'b1;
                  kind_q <= PK_ADD;
                  ost    <= O_ADD;
               end else if (bit_end) begin
                  if (last_bit) begin
                     done_q <= 1'b1;
                     ost    <= O_IDLE;
                  end else begin
                     bit_cnt <= bit_cnt + 1'b1;
                     kick_q  <= 1'b1;
                     kind_q  <= PK_DBL;
                     ost     <= O_DBL;
                  end
               end
            end
            default: ost <= O_IDLE;
         endcase
      end
   end

   assign busy_o = (ost != O_IDLE);
   assign done_o = done_q;

   initial begin
      assert ((1 << LW) > KMAX) else $error("ecsm_seq_ctrl: LW too narrow for KMAX");
   end

   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done_o |-> !busy_o); // R7
   AST_BIT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) busy_o |-> (bit_cnt < len_q)); // R7
   AST_ADD_AFTER_DBL: assert property (@(posedge clk) disable iff (!rst_n) (kick_q && kind_q == PK_ADD) |-> ($past(ost) == O_DBL)); // R4
   AST_BUSY_START_IGN: assert property (@(posedge clk) disable iff (!rst_n) (busy_o && start_i) |=> !(kick_q && kind_q == PK_INIT)); // R9
   AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n) (bit_end && stop_i) |=> (done_o && !busy_o)); // R8

endmodule

// File: tb/ecsm_seq_ctrl_bench.sv
module ecsm_seq_ctrl_bench;

   localparam int KMAX = 261;
   localparam int LW   = 9;
   localparam int IDXW = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start_i = 1'b0;
   logic            stop_i = 1'b0;
   logic [LW-1:0]   len_i = '0;
   logic            scalar_load_i = 1'b0;
   logic [KMAX-1:0] scalar_i = '0;
   logic            cmd_req_o;
   logic [2:0]      cmd_op_o;
   logic [IDXW-1:0] cmd_idx_o;
   logic            cmd_ack_i = 1'b0;
   logic            busy_o;
   logic            done_o;

   always #5 clk = ~clk;

   ecsm_seq_ctrl u_ecsm_seq_ctrl (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i), .len_i(len_i),
      .scalar_load_i(scalar_load_i), .scalar_i(scalar_i), .cmd_req_o(cmd_req_o),
      .cmd_op_o(cmd_op_o), .cmd_idx_o(cmd_idx_o), .cmd_ack_i(cmd_ack_i),
      .busy_o(busy_o), .done_o(done_o)
   );

   typedef struct {
      logic [2:0]      op;
      logic [IDXW-1:0] idx;
      string           tag;
   } item_t;

   item_t q[$];
   int total = 0;
   int bad = 0;
   int mul_seen = 0;
   int wait_cnt = 0;
   bit outstanding = 0;
   bit spur_idle = 0;
   bit spur_req = 0;
   bit req_prev = 0;
   logic [2:0] held_op;
   logic [IDXW-1:0] held_idx;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   task automatic push(input int op, input int idx, input string tag);
      item_t it;
      it.op = 3'(op);
      it.idx = IDXW'(idx);
      it.tag = tag;
      q.push_back(it);
   endtask

   // monitor and responder (scoreboard pop side)
   always @(negedge clk) begin
      if (rst_n) begin
         cmd_ack_i = 1'b0;
         if (outstanding && !cmd_req_o) begin
            // R5: fields held while waiting
            chk(cmd_op_o == held_op, "R5 op held", int'(cmd_op_o), int'(held_op));
            chk(cmd_idx_o == held_idx, "R5 idx held", int'(cmd_idx_o), int'(held_idx));
         end
         if (wait_cnt > 0) begin
            wait_cnt--;
            if (wait_cnt == 0) begin
               cmd_ack_i = 1'b1;
               outstanding = 0;
            end
         end
         if (cmd_req_o) begin
            chk(!req_prev, "R5 single-cycle req", 1, 0);
            chk(!outstanding, "R6 req before ack", 1, 0);
            if (q.size() == 0) begin
               chk(0, "R6 unexpected req", int'(cmd_op_o), -1);
            end else begin
               item_t it;
               it = q.pop_front();
               chk(cmd_op_o == it.op, {it.tag, " op"}, int'(cmd_op_o), int'(it.op));
               chk(cmd_idx_o == it.idx, {it.tag, " idx"}, int'(cmd_idx_o), int'(it.idx));
            end
            if (cmd_op_o == 3'd2) mul_seen++;
            held_op = cmd_op_o;
            held_idx = cmd_idx_o;
            outstanding = 1;
            wait_cnt = $urandom_range(1, 3);
            if (spur_req) cmd_ack_i = 1'b1; // R6: same-cycle ack must be ignored
         end
         if (spur_idle && !busy_o) cmd_ack_i = 1'b1;
         req_prev = cmd_req_o;
      end
   end

   // driver: pushes expected commands and runs one point multiplication
   task automatic run(input logic [KMAX-1:0] s, input int n, input bit stp, input bit disturb);
      int nb;
      int exp_mul;
      nb = stp ? 1 : n;
      exp_mul = 0;
      push(4, 0, "R2"); push(5, 0, "R2"); push(6, 0, "R2");
      for (int b = 0; b < nb; b++) begin
         for (int m = 0; m < 7; m++)
            for (int k = 0; k < 4; k++) push(k, m, "R4");
         exp_mul += 7;
         if (s[KMAX-1-b]) begin
            for (int m = 0; m < 13; m++)
               for (int k = 0; k < 4; k++) push(k, m, "R3");
            exp_mul += 13;
         end
      end
      @(negedge clk);
      scalar_i = s; scalar_load_i = 1'b1;
      @(negedge clk);
      scalar_load_i = 1'b0;
      len_i = LW'(n); stop_i = stp; mul_seen = 0;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      if (disturb) begin
         repeat (40) @(negedge clk);
         start_i = 1'b1; scalar_load_i = 1'b1; scalar_i = ~s; // R9
         @(negedge clk);
         start_i = 1'b0; scalar_load_i = 1'b0;
      end
      while (!done_o) @(negedge clk);
      chk(!busy_o, "R7 busy low at done", int'(busy_o), 0);
      chk(q.size() == 0, stp ? "R8 stream complete" : "R7 stream complete", q.size(), 0);
      chk(mul_seen == exp_mul, "R10 multiply count", mul_seen, exp_mul);
      repeat (5) @(negedge clk);
      chk(done_o && !busy_o, "R7 done held", int'(done_o), 1);
      stop_i = 1'b0;
      q.delete();
   endtask

   initial begin
      logic [KMAX-1:0] s;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(!cmd_req_o, "R1 req", int'(cmd_req_o), 0);
      chk(!busy_o, "R1 busy", int'(busy_o), 0);
      chk(!done_o, "R1 done", int'(done_o), 0);
      rst_n = 1'b1;
      // R6: completions while idle are ignored
      spur_idle = 1;
      repeat (10) @(negedge clk);
      spur_idle = 0;
      chk(!busy_o && !done_o, "R6 idle ack ignored", int'(busy_o), 0);
      s = '0; s[KMAX-1 -: 8] = 8'b1011_0011;
      run(s, 8, 0, 1);                   // R3 R9
      s = '0;
      run(s, 1, 0, 0);                   // single zero bit
      s[KMAX-1] = 1'b1;
      run(s, 1, 0, 0);                   // single one bit
      s = '1;
      spur_req = 1;
      run(s, 5, 0, 0);                   // all ones, R6 same-cycle acks
      spur_req = 0;
      s = '0;
      run(s, 6, 0, 0);                   // all zeros
      for (int i = 0; i < KMAX; i++) s[i] = 1'($urandom_range(0, 1));
      run(s, 20, 1, 0);                  // R8 stop held
      run(s, 37, 0, 0);
      for (int i = 0; i < KMAX; i++) s[i] = 1'($urandom_range(0, 1));
      run(s, KMAX, 0, 0);                // R10 full length
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL R7 watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule